// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Control and Lock Pin

This block sits between the reference and VCO dividers of one synthesizer loop and the charge-pump current switches. It receives the divided reference strobe and the divided VCO strobe, both one clock wide and synchronous to a fast system clock. From them it produces a pump-up (sourcing) enable and a pump-down (sinking) enable. When neither enable is active the pump idles in tristate. After both strobes have been seen, the two enables overlap for a programmable number of clock cycles and then clear together. Because every comparison produces some output, the detector has no dead zone.

A polarity input swaps the sourcing and sinking sides so that VCOs with either tuning slope can be used. A two-bit code selects the current magnitude, which is passed on as an ordinal index. A standby code parks the detector and releases the outputs. A shared output pin carries either a pulse-width-modulated lock indication or, for test, one of the divided strobes. A select input can hand the pin to a partner loop.

Top module: `pfd_polarity_lock`

## Requirements
- R1: After a cycle with `rst` high, `up_en` and `dn_en` are 0 and `pump_hiz` is 1 until a strobe arrives. In pin mode 11 with `loop_sel`=0 and `stby`=11, `pin_val` is 1.
- R2: Positive polarity is `pol_pos`=1. When a reference strobe comes first, `up_en` rises on the next cycle and `dn_en` stays 0. When a VCO strobe comes first, `dn_en` rises instead. With `pol_pos`=0 the two enables are exchanged.
- R3: If both strobes have been seen, or both arrive in the same cycle, `up_en` and `dn_en` are both 1 from the next cycle for exactly the selected number of cycles. Both are then 0.
- R4: The overlap length follows `pw_code`: 00 gives PW_CYC_A, 10 gives PW_CYC_B, 01 gives PW_CYC_C and 11 gives PW_CYC_D clock cycles (defaults 1, 4, 6, 9).
- R5: A strobe that arrives while both enables are 1 is dropped. After the overlap, both enables return to 0.
- R6: In pin mode 11 with `loop_sel`=0 and `lock_mute`=0, `pin_val` is 1 when neither pump enable is active and 0 when either is active.
- R7: `lock_mute`=1 holds `pin_val` at 1 in pin mode 11 with `loop_sel`=0, whatever the phase error.
- R8: `pin_mode` selects what the pin carries: 00 the VCO strobe, 01 the reference strobe, 10 (reserved) the reference strobe, 11 the lock signal. With `loop_sel`=1 these come from `partner_vco`, `partner_ref` and `partner_lock`.
- R9: Any `stby` value other than 11 forces `up_en`=`dn_en`=0, `pump_hiz`=1, `pin_oe`=0 and `pin_val`=0, and clears the detector state. After `stby` returns to 11, neither enable is active until a new strobe arrives.
- R10: `cur_mag` is the ascending current index for `cur_code`: 00 gives 0 (smallest), 10 gives 1, 01 gives 2 and 11 gives 3 (largest).
- R11: While operating, `pump_hiz` is 1 exactly when neither `up_en` nor `dn_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock |
| rst | input | 1 | synchronous active-high reset |
| ref_pulse | input | 1 | divided reference strobe, one cycle wide |
| vco_pulse | input | 1 | divided VCO strobe, one cycle wide |
| pol_pos | input | 1 | 1 positive polarity, 0 negative |
| pw_code | input | 2 | overlap-width code |
| cur_code | input | 2 | current magnitude code |
| lock_mute | input | 1 | 1 holds the lock signal at its idle high level |
| pin_mode | input | 2 | shared pin source select |
| loop_sel | input | 1 | 1 routes the partner loop to the pin |
| stby | input | 2 | 11 operating, anything else standby |
| partner_ref | input | 1 | partner loop reference strobe |
| partner_vco | input | 1 | partner loop VCO strobe |
| partner_lock | input | 1 | partner loop lock signal |
| up_en | output | 1 | sourcing pump enable |
| dn_en | output | 1 | sinking pump enable |
| cur_mag | output | 2 | current magnitude index |
| pump_hiz | output | 1 | pump output is tristate |
| pin_val | output | 1 | shared pin value |
| pin_oe | output | 1 | shared pin drive enable |

## Verification
The assertions take the strobes to be synchronous single-cycle events sampled on the rising clock edge. They take every overlap width to be at least one cycle and no larger than the package default limit. The stimulus changes every input just after a rising edge and never holds a strobe high longer than one cycle in the directed phases. The random phase draws each strobe fresh every cycle, so back-to-back strobes act as separate events, which the detector tolerates.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int DEF_PW_A = 1;
    localparam int DEF_PW_B = 4;
    localparam int DEF_PW_C = 6;
    localparam int DEF_PW_D = 9;

    localparam logic [1:0] STBY_RUN = 2'b11;

    typedef enum logic [1:0] {
        PIN_VCO  = 2'b00,
        PIN_REF  = 2'b01,
        PIN_RSVD = 2'b10,
        PIN_LOCK = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic ref_hit;
        logic vco_hit;
    } pfd_state_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    localparam int PW_LIMIT_DEFAULT = max4(DEF_PW_A, DEF_PW_B, DEF_PW_C, DEF_PW_D);

    function automatic int pw_cycles(input logic [1:0] code,
                                     input int a, input int b, input int c, input int d);
        case (code)
            2'b00:   return a;
            2'b10:   return b;
            2'b01:   return c;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int PW_A = DEF_PW_A,
    parameter int PW_B = DEF_PW_B,
    parameter int PW_C = DEF_PW_C,
    parameter int PW_D = DEF_PW_D,
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       ref_pulse,
    input  logic       vco_pulse,
    input  logic [1:0] pw_code,
    output pfd_state_t st
);
    logic [CNT_W-1:0] hold_cnt;
    logic [CNT_W-1:0] limit_m1;

    always_comb limit_m1 = CNT_W'(pw_cycles(pw_code, PW_A, PW_B, PW_C, PW_D) - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st       <= '0;
            hold_cnt <= '0;
        end else if (st.ref_hit && st.vco_hit) begin
            // both edges seen: hold the overlap, then release together
            if (hold_cnt >= limit_m1) begin
                st       <= '0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else begin
            st.ref_hit <= st.ref_hit | ref_pulse;
            st.vco_hit <= st.vco_hit | vco_pulse;
        end
    end
endmodule

// File: rtl/pfd_pump_map.sv
module pfd_pump_map
    import pfd_pkg::*;
(
    input  logic       run,
    input  logic       pol_pos,
    input  logic [1:0] cur_code,
    input  pfd_state_t st,
    output logic       up_en,
    output logic       dn_en,
    output logic       pump_hiz,
    output logic [1:0] cur_mag
);
    logic src_side;
    logic snk_side;

    always_comb begin
        // positive slope: reference ahead sources, VCO ahead sinks
        src_side = pol_pos ? st.ref_hit : st.vco_hit;
        snk_side = pol_pos ? st.vco_hit : st.ref_hit;
        up_en    = run & src_side;
        dn_en    = run & snk_side;
        pump_hiz = ~(up_en | dn_en);
        cur_mag  = {cur_code[0], cur_code[1]};
    end
endmodule

// File: rtl/pfd_pin_mux.sv
module pfd_pin_mux
    import pfd_pkg::*;
(
    input  logic       run,
    input  logic [1:0] pin_mode,
    input  logic       loop_sel,
    input  logic       lock_mute,
    input  pfd_state_t st,
    input  logic       ref_pulse,
    input  logic       vco_pulse,
    input  logic       partner_ref,
    input  logic       partner_vco,
    input  logic       partner_lock,
    output logic       pin_val,
    output logic       pin_oe
);
    logic own_lock;
    logic src_ref;
    logic src_vco;
    logic src_lock;

    always_comb begin
        own_lock = lock_mute | ~(st.ref_hit | st.vco_hit);
        src_ref  = loop_sel ? partner_ref  : ref_pulse;
        src_vco  = loop_sel ? partner_vco  : vco_pulse;
        src_lock = loop_sel ? partner_lock : own_lock;
        case (pin_mode_e'(pin_mode))
            PIN_VCO:  pin_val = src_vco;
            PIN_REF:  pin_val = src_ref;
            PIN_RSVD: pin_val = src_ref;
            default:  pin_val = src_lock;
        endcase
        if (!run) pin_val = 1'b0;
        pin_oe = run;
    end
endmodule

// File: rtl/pfd_polarity_lock.sv
module pfd_polarity_lock
    import pfd_pkg::*;
#(
    parameter int PW_CYC_A = DEF_PW_A,
    parameter int PW_CYC_B = DEF_PW_B,
    parameter int PW_CYC_C = DEF_PW_C,
    parameter int PW_CYC_D = DEF_PW_D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_pulse,
    input  logic       vco_pulse,
    input  logic       pol_pos,
    input  logic [1:0] pw_code,
    input  logic [1:0] cur_code,
    input  logic       lock_mute,
    input  logic [1:0] pin_mode,
    input  logic       loop_sel,
    input  logic [1:0] stby,
    input  logic       partner_ref,
    input  logic       partner_vco,
    input  logic       partner_lock,
    output logic       up_en,
    output logic       dn_en,
    output logic [1:0] cur_mag,
    output logic       pump_hiz,
    output logic       pin_val,
    output logic       pin_oe
);
    localparam int PW_MAX = max4(PW_CYC_A, PW_CYC_B, PW_CYC_C, PW_CYC_D);
    localparam int CNT_W  = $clog2(PW_MAX + 1);

    logic       run;
    pfd_state_t st;

    assign run = (stby == STBY_RUN);

    pfd_core #(
        .PW_A(PW_CYC_A), .PW_B(PW_CYC_B), .PW_C(PW_CYC_C), .PW_D(PW_CYC_D), .CNT_W(CNT_W)
    ) u_core (
        .clk(clk), .rst(rst), .run(run),
        .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .pw_code(pw_code), .st(st)
    );

    pfd_pump_map u_pump (
        .run(run), .pol_pos(pol_pos), .cur_code(cur_code), .st(st),
        .up_en(up_en), .dn_en(dn_en), .pump_hiz(pump_hiz), .cur_mag(cur_mag)
    );

    pfd_pin_mux u_pin (
        .run(run), .pin_mode(pin_mode), .loop_sel(loop_sel), .lock_mute(lock_mute),
        .st(st), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
        .partner_ref(partner_ref), .partner_vco(partner_vco), .partner_lock(partner_lock),
        .pin_val(pin_val), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/pfd_polarity_lock_chk.sv
module pfd_polarity_lock_chk
    import pfd_pkg::*;
#(
    parameter int PW_LIMIT = PW_LIMIT_DEFAULT
) (
    input logic       clk,
    input logic       rst,
    input logic       ref_pulse,
    input logic       vco_pulse,
    input logic       pol_pos,
    input logic [1:0] stby,
    input logic [1:0] pin_mode,
    input logic       loop_sel,
    input logic       lock_mute,
    input logic       up_en,
    input logic       dn_en,
    input logic       pump_hiz,
    input logic       pin_val,
    input logic       pin_oe
);
    logic op;
    int   ov_len;

    assign op = (stby == STBY_RUN);

    always_ff @(posedge clk) begin
        if (rst)                 ov_len <= 0;
        else if (up_en && dn_en) ov_len <= ov_len + 1;
        else                     ov_len <= 0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!up_en && !dn_en));

    assert_lead_side_R2: assert property (@(posedge clk) disable iff (rst)
        (op && ref_pulse && !vco_pulse && !up_en && !dn_en) ##1 (op && pol_pos)
        |-> (up_en && !dn_en));

    assert_overlap_bound_R4: assert property (@(posedge clk) disable iff (rst)
        ov_len <= PW_LIMIT);

    assert_lock_tracks_pump_R6: assert property (@(posedge clk) disable iff (rst)
        (op && pin_mode == 2'b11 && !loop_sel && !lock_mute && !pin_val)
        |-> (up_en || dn_en));

    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!op) |-> (!up_en && !dn_en && pump_hiz && !pin_oe));
endmodule

bind pfd_polarity_lock pfd_polarity_lock_chk u_chk (.*);

// File: tb/test_pfd_polarity_lock.sv
module test_pfd_polarity_lock;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_pulse = 1'b0, vco_pulse = 1'b0, pol_pos = 1'b1;
    logic [1:0] pw_code = 2'b00, cur_code = 2'b00, pin_mode = 2'b11, stby = 2'b11;
    logic       lock_mute = 1'b0, loop_sel = 1'b0;
    logic       partner_ref = 1'b0, partner_vco = 1'b0, partner_lock = 1'b0;
    logic       up_en, dn_en, pump_hiz, pin_val, pin_oe;
    logic [1:0] cur_mag;

    int vectors = 0;
    int miscompares = 0;
    bit m_ref = 0, m_vco = 0;
    int m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_polarity_lock i_pfd_polarity_lock (.*);

    function automatic int width_of(input logic [1:0] c);
        case (c)
            2'b00: return 1;
            2'b10: return 4;
            2'b01: return 6;
            default: return 9;
        endcase
    endfunction

    task automatic step(input string tag);
        bit op, e_up, e_dn, e_hiz, e_val, e_oe, lk, r_src, v_src, l_src;
        int e_mag;
        @(negedge clk);
        #1;
        op    = (stby == 2'b11);
        e_up  = op && (pol_pos ? m_ref : m_vco);
        e_dn  = op && (pol_pos ? m_vco : m_ref);
        e_hiz = !(e_up || e_dn);
        e_mag = (cur_code == 2'b00) ? 0 : (cur_code == 2'b10) ? 1 : (cur_code == 2'b01) ? 2 : 3;
        lk    = lock_mute || !(m_ref || m_vco);
        r_src = loop_sel ? partner_ref : ref_pulse;
        v_src = loop_sel ? partner_vco : vco_pulse;
        l_src = loop_sel ? partner_lock : lk;
        e_val = !op ? 1'b0 : (pin_mode == 2'b00) ? v_src : (pin_mode == 2'b11) ? l_src : r_src;
        e_oe  = op;
        vectors++;
        if (up_en !== e_up || dn_en !== e_dn || pump_hiz !== e_hiz || cur_mag !== 2'(e_mag)
            || pin_val !== e_val || pin_oe !== e_oe) begin
            miscompares++;
            $display("FAIL %s t=%0t got up=%b dn=%b hiz=%b mag=%0d pin=%b oe=%b exp up=%b dn=%b hiz=%b mag=%0d pin=%b oe=%b",
                     tag, $time, up_en, dn_en, pump_hiz, cur_mag, pin_val, pin_oe,
                     e_up, e_dn, e_hiz, e_mag, e_val, e_oe);
        end
        // next state for the coming rising edge
        if (rst || !op) begin
            m_ref = 0; m_vco = 0; m_cnt = 0;
        end else if (m_ref && m_vco) begin
            if (m_cnt >= width_of(pw_code) - 1) begin m_ref = 0; m_vco = 0; m_cnt = 0; end
            else m_cnt++;
        end else begin
            m_ref = m_ref | ref_pulse;
            m_vco = m_vco | vco_pulse;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic strobe(input bit r, input bit v, input string tag);
        ref_pulse = r; vco_pulse = v;
        step(tag);
        ref_pulse = 0; vco_pulse = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired, all requirements unfinished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1 reset state
        idle(2, "R1");
        rst = 0;
        idle(3, "R1");
        // R2 reference leads, positive polarity
        strobe(1, 0, "R2"); idle(3, "R2"); strobe(0, 1, "R2"); idle(6, "R2");
        // R2 VCO leads, positive polarity
        strobe(0, 1, "R2"); idle(2, "R2"); strobe(1, 0, "R2"); idle(6, "R2");
        // R2 negative polarity swaps sides
        pol_pos = 0;
        strobe(1, 0, "R2"); idle(2, "R2"); strobe(0, 1, "R2"); idle(6, "R2");
        strobe(0, 1, "R2"); idle(2, "R2"); strobe(1, 0, "R2"); idle(6, "R2");
        pol_pos = 1;
        // R3 R4 in-phase strobes for every width code
        for (int c = 0; c < 4; c++) begin
            pw_code = 2'(c);
            strobe(1, 1, "R3"); idle(11, "R4");
        end
        // R5 strobes during the overlap are dropped
        pw_code = 2'b11;
        strobe(1, 1, "R5"); idle(2, "R5"); strobe(1, 0, "R5"); strobe(0, 1, "R5");
        idle(10, "R5");
        // R6 lock pin follows pump activity
        pin_mode = 2'b11;
        strobe(1, 0, "R6"); idle(2, "R6"); strobe(0, 1, "R6"); idle(10, "R6");
        // R7 lock muted
        lock_mute = 1;
        strobe(0, 1, "R7"); idle(2, "R7"); strobe(1, 0, "R7"); idle(10, "R7");
        lock_mute = 0;
        // R8 pin routing, own and partner loop
        for (int s = 0; s < 2; s++) begin
            loop_sel = s[0];
            for (int m = 0; m < 4; m++) begin
                pin_mode = 2'(m);
                partner_lock = 1; strobe(1, 0, "R8");
                partner_vco = 1; strobe(0, 1, "R8"); partner_vco = 0;
                partner_ref = 1; step("R8"); partner_ref = 0;
                partner_lock = 0; idle(10, "R8");
            end
        end
        loop_sel = 0; pin_mode = 2'b11;
        // R9 standby mid-pulse clears the detector
        for (int k = 0; k < 3; k++) begin
            strobe(1, 0, "R9"); idle(1, "R9");
            stby = 2'(k);
            idle(3, "R9");
            stby = 2'b11;
            idle(3, "R9");
        end
        // R10 current code mapping
        for (int c = 0; c < 4; c++) begin
            cur_code = 2'(c);
            idle(2, "R10");
        end
        // R11 tristate flag under random traffic
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                pol_pos = 1'($urandom);
                pw_code = 2'($urandom);
                cur_code = 2'($urandom);
                pin_mode = 2'($urandom);
                loop_sel = 1'($urandom);
                lock_mute = ($urandom % 4) == 0;
            end
            stby = (($urandom % 64) == 0) ? 2'($urandom) : 2'b11;
            partner_ref = ($urandom % 5) == 0;
            partner_vco = ($urandom % 5) == 0;
            partner_lock = 1'($urandom);
            strobe(($urandom % 7) == 0, ($urandom % 7) == 0, "R11");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule